// File: doc/BRIEF.md
# Two-Quarter Vending Sequencer with Jam Lockout

This block is the control core of a small beverage vending unit. It sees only single-cycle event pulses: a quarter has been accepted, one or more product buttons are pressed, the customer has removed the bottle, the bottle path is jammed, and the jam has been cleared. From these pulses it drives a one-cycle dispense strobe for each product. It also drives three level indications: waiting for a selection, waiting for the bottle to be taken, and locked out.

A purchase runs in a fixed order. The price, two quarters by default, is collected first. One product is then chosen and dispensed. The customer must take the bottle before any new money is counted. A jam indication overrides every other state and input. While locked, the unit refuses money and dispenses nothing. The lockout ends only on a clear event, and the customer loses any credit held when the jam arrived.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, all dispense strobes are 0, `paid_o`, `wait_take_o` and `locked_o` are 0, and `credit_o` is 0.
- R2: In the idle or partial-credit state, each `coin_i` pulse raises `credit_o` by one in the next cycle. When the count reaches PRICE (2 by default), `paid_o` is 1 from that next cycle on.
- R3: While `paid_o` is 1 and at least one `sel_i` bit is set, `vend_o` carries a strobe for the chosen product in the next cycle and is 0 in the cycle after it. In that same next cycle `wait_take_o` becomes 1, `paid_o` becomes 0 and `credit_o` becomes 0. Bit k of `vend_o` belongs to product k, which is selected by bit k of `sel_i`.
- R4: When several `sel_i` bits are set in the same cycle, only the lowest-numbered one is dispensed, and `vend_o` never has more than one bit set.
- R5: A selection made in the idle or partial-credit state is ignored. No strobe is issued, and the state and `credit_o` are unchanged unless a coin also arrives in that cycle.
- R6: A `coin_i` pulse made while `paid_o` or `wait_take_o` is 1 is ignored. `credit_o` and the state are unchanged by it.
- R7: While `wait_take_o` is 1, `take_i` returns the unit to idle in the next cycle with `credit_o` 0. Selections made while waiting are ignored.
- R8: `jam_i` in any state sets `locked_o` in the next cycle, clears `credit_o` and suppresses any strobe. It takes priority over every other input in the same cycle, including `clear_i`.
- R9: While `locked_o` is 1, coins, selections and `take_i` have no effect. `clear_i` without `jam_i` returns the unit to idle with `credit_o` 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_i | input | 1 | One-cycle pulse: a quarter has been accepted |
| sel_i | input | N_PROD | Product buttons, bit k selects product k |
| take_i | input | 1 | One-cycle pulse: the bottle has been removed |
| jam_i | input | 1 | One-cycle pulse: a stuck bottle has been detected |
| clear_i | input | 1 | One-cycle pulse: the jam has been cleared |
| vend_o | output | N_PROD | One-cycle dispense strobe, bit k for product k |
| paid_o | output | 1 | Price collected, waiting for a selection |
| wait_take_o | output | 1 | Product dispensed, waiting for the bottle to be taken |
| locked_o | output | 1 | Jam lockout active |
| credit_o | output | $clog2(PRICE+1) | Quarters counted toward the current purchase |

## Verification
The bench targets several corner cases, each tied to a specific wrong behaviour:
- A jam arriving in the same cycle as a selection in the paid state. A design that let the selection win would emit a strobe and enter the wait-for-take state instead of locking.
- A jam arriving together with a clear. A design with the wrong priority would fall back to idle.
- Several buttons pressed at once. A wrong priority encoder would emit the wrong product or more than one strobe bit.
- Extra quarters fed in the paid and waiting states, and early selections fed before payment. A design that miscounted would show a credit above the price or dispense before payment.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [2:0] {
    VS_IDLE   = 3'd0,
    VS_CREDIT = 3'd1,
    VS_PAID   = 3'd2,
    VS_TAKE   = 3'd3,
    VS_JAM    = 3'd4
  } vend_state_e;
endpackage

// File: rtl/vend_pick.sv
// Fixed-priority one-hot picker: lowest-numbered request wins.
module vend_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pri
    assign gnt_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end
  assign any_o = seen[N];

  always_comb begin
    a_gnt_onehot_r4: assert ($onehot0(gnt_o));
  end
endmodule

// File: rtl/vend_credit.sv
// Quarter counter toward the price.
module vend_credit #(
  parameter int PRICE = 2,
  localparam int CW = $clog2(PRICE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          clr_i,
  output logic [CW-1:0] count_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST = CW'(PRICE - 1);
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)        count_q <= '0;
    else if (clr_i) count_q <= '0;
    else if (inc_i) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
  assign last_o  = (count_q == LAST);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(PRICE));
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> count_q == '0);
endmodule

// File: rtl/vend_fsm.sv
// Purchase sequencer with overriding jam lockout.
module vend_fsm
  import vend_pkg::*;
#(
  parameter int N_PROD = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coin_i,
  input  logic [N_PROD-1:0] gnt_i,
  input  logic              any_sel_i,
  input  logic              take_i,
  input  logic              jam_i,
  input  logic              clear_i,
  input  logic              last_i,
  output logic              inc_o,
  output logic              clr_o,
  output logic [N_PROD-1:0] vend_o,
  output logic              paid_o,
  output logic              wait_take_o,
  output logic              locked_o
);
  vend_state_e       st_q, st_n;
  logic [N_PROD-1:0] vend_n;

  always_comb begin
    st_n   = st_q;
    vend_n = '0;
    inc_o  = 1'b0;
    clr_o  = 1'b0;
    if (jam_i) begin
      st_n  = VS_JAM;
      clr_o = 1'b1;
    end else begin
      case (st_q)
        VS_IDLE, VS_CREDIT: begin
          if (coin_i) begin
            inc_o = 1'b1;
            st_n  = last_i ? VS_PAID : VS_CREDIT;
          end
        end
        VS_PAID: begin
          if (any_sel_i) begin
            vend_n = gnt_i;
            clr_o  = 1'b1;
            st_n   = VS_TAKE;
          end
        end
        VS_TAKE: if (take_i)  st_n = VS_IDLE;
        VS_JAM:  if (clear_i) st_n = VS_IDLE;
        default: st_n = VS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= VS_IDLE;
      vend_o      <= '0;
      paid_o      <= 1'b0;
      wait_take_o <= 1'b0;
      locked_o    <= 1'b0;
    end else begin
      st_q        <= st_n;
      vend_o      <= vend_n;
      paid_o      <= (st_n == VS_PAID);
      wait_take_o <= (st_n == VS_TAKE);
      locked_o    <= (st_n == VS_JAM);
    end
  end

  p_vend_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vend_o));
  p_vend_needs_paid_r3: assert property (@(posedge clk) disable iff (rst)
    (|vend_o) |-> ($past(st_q) == VS_PAID) && wait_take_o);
  p_vend_single_r3: assert property (@(posedge clk) disable iff (rst)
    (|vend_o) |=> (vend_o == '0));
  p_early_sel_r5: assert property (@(posedge clk) disable iff (rst)
    ((st_q == VS_IDLE || st_q == VS_CREDIT) && !jam_i && !coin_i) |=> $stable(st_q));
  p_paid_coin_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == VS_PAID && !jam_i && !any_sel_i) |=> st_q == VS_PAID);
  p_take_exit_r7: assert property (@(posedge clk) disable iff (rst)
    (wait_take_o && take_i && !jam_i) |=> (st_q == VS_IDLE) && !wait_take_o);
  p_jam_locks_r8: assert property (@(posedge clk) disable iff (rst)
    jam_i |=> locked_o && (vend_o == '0));
  p_clear_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (locked_o && clear_i && !jam_i) |=> !locked_o && (st_q == VS_IDLE));
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
  parameter int N_PROD = 3,
  parameter int PRICE  = 2,
  localparam int CW = $clog2(PRICE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coin_i,
  input  logic [N_PROD-1:0] sel_i,
  input  logic              take_i,
  input  logic              jam_i,
  input  logic              clear_i,
  output logic [N_PROD-1:0] vend_o,
  output logic              paid_o,
  output logic              wait_take_o,
  output logic              locked_o,
  output logic [CW-1:0]     credit_o
);
  logic [N_PROD-1:0] gnt;
  logic              any_sel, inc, clr, last;

  vend_pick #(.N(N_PROD)) u_pick (
    .req_i(sel_i), .gnt_o(gnt), .any_o(any_sel)
  );

  vend_credit #(.PRICE(PRICE)) u_credit (
    .clk(clk), .rst(rst), .inc_i(inc), .clr_i(clr),
    .count_o(credit_o), .last_o(last)
  );

  vend_fsm #(.N_PROD(N_PROD)) u_fsm (
    .clk(clk), .rst(rst), .coin_i(coin_i), .gnt_i(gnt), .any_sel_i(any_sel),
    .take_i(take_i), .jam_i(jam_i), .clear_i(clear_i), .last_i(last),
    .inc_o(inc), .clr_o(clr), .vend_o(vend_o), .paid_o(paid_o),
    .wait_take_o(wait_take_o), .locked_o(locked_o)
  );
endmodule

// File: tb/tb_vend_ctrl.sv
`timescale 1ns/1ps
module tb_vend_ctrl;
  localparam int N = 3;
  localparam int PRICE = 2;
  localparam int CW = $clog2(PRICE + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic coin = 0, take = 0, jam = 0, clr = 0;
  logic [N-1:0] sel = '0;
  logic [N-1:0] vend;
  logic paid, waitt, locked;
  logic [CW-1:0] credit;

  int errors = 0, checks = 0;
  bit done = 0;

  // model state: 0 idle, 1 partial, 2 paid, 3 wait take, 4 locked
  int m_st = 0, m_cr = 0;
  logic [N-1:0] m_vend = '0;

  always #5 clk = ~clk;

  vend_ctrl #(.N_PROD(N), .PRICE(PRICE)) dut (
    .clk(clk), .rst(rst), .coin_i(coin), .sel_i(sel), .take_i(take),
    .jam_i(jam), .clear_i(clr), .vend_o(vend), .paid_o(paid),
    .wait_take_o(waitt), .locked_o(locked), .credit_o(credit)
  );

  function automatic logic [N-1:0] lowest(input logic [N-1:0] r);
    for (int i = 0; i < N; i++) if (r[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic string tag_of(input int st, input logic c, input logic [N-1:0] s,
                                   input logic j);
    if (j) return "R8";
    if (st == 4) return "R9";
    if (st == 2 && $countones(s) > 1) return "R4";
    if (st == 2 && s != 0) return "R3";
    if ((st == 2 || st == 3) && c) return "R6";
    if (st == 3) return "R7";
    if ((st == 0 || st == 1) && s != 0) return "R5";
    return "R2";
  endfunction

  task automatic model_step();
    m_vend = '0;
    if (jam) begin m_st = 4; m_cr = 0; end
    else case (m_st)
      0, 1: if (coin) begin m_cr++; m_st = (m_cr == PRICE) ? 2 : 1; end
      2: if (sel != 0) begin m_vend = lowest(sel); m_st = 3; m_cr = 0; end
      3: if (take) m_st = 0;
      4: if (clr) m_st = 0;
      default: m_st = 0;
    endcase
  endtask

  task automatic compare(input string tag);
    logic [N+3+CW-1:0] act, exp;
    act = {vend, paid, waitt, locked, credit};
    exp = {m_vend, m_st == 2, m_st == 3, m_st == 4, CW'(m_cr)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t vend/paid/wait/lock/credit actual=%b expected=%b",
               tag, $time, act, exp);
    end
  endtask

  // drive one cycle of inputs, then check the registered result
  task automatic step(input logic c, input logic [N-1:0] s, input logic t,
                      input logic j, input logic cl);
    string tg;
    coin = c; sel = s; take = t; jam = j; clr = cl;
    tg = tag_of(m_st, c, s, j);
    model_step();
    @(posedge clk); #1;
    compare(tg);
  endtask

  task automatic idle_cycle(); step(0, '0, 0, 0, 0); endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    compare("R1");            // R1 during reset
    rst = 1'b0;
    @(posedge clk); #1;
    compare("R1");            // R1 first cycle after release

    // R5: early selections before payment
    step(0, 3'b001, 0, 0, 0);
    step(1, '0, 0, 0, 0);     // R2 first quarter
    step(0, 3'b100, 0, 0, 0); // R5 in partial
    step(1, '0, 0, 0, 0);     // R2 paid
    step(1, '0, 0, 0, 0);     // R6 extra quarter in paid
    step(0, 3'b110, 0, 0, 0); // R4 lowest wins -> product 1
    idle_cycle();             // R3 strobe gone
    step(1, 3'b001, 0, 0, 0); // R6/R7 ignored while waiting
    step(0, '0, 1, 0, 0);     // R7 take
    // R8: jam beats a selection in paid
    step(1, '0, 0, 0, 0);
    step(1, '0, 0, 0, 0);
    step(0, 3'b001, 0, 1, 0);
    step(1, 3'b111, 1, 0, 0); // R9 ignored while locked
    step(0, '0, 0, 1, 1);     // R8 jam beats clear
    step(0, '0, 0, 0, 1);     // R9 clear
    // R8: jam with partial credit loses it
    step(1, '0, 0, 0, 0);
    step(0, '0, 0, 1, 0);
    step(0, '0, 0, 0, 1);
    // R3 each product on its own
    for (int k = 0; k < N; k++) begin
      step(1, '0, 0, 0, 0);
      step(1, '0, 0, 0, 0);
      step(0, N'(1) << k, 0, 0, 0);
      step(0, '0, 1, 0, 0);
    end

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic c, t, j, cl;
      logic [N-1:0] s;
      c  = ($urandom % 100) < 30;
      s  = (($urandom % 100) < 30) ? N'($urandom) : '0;
      t  = ($urandom % 100) < 20;
      j  = ($urandom % 100) < 3;
      cl = ($urandom % 100) < 15;
      step(c, s, t, j, cl);
    end
    idle_cycle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule